// File: doc/BRIEF.md
# DCC Track Bit Waveform Generator

This block produces the two-level track signal for a DCC-style bitstream. An internal divider turns the system clock into a fixed periodic tick of about 58 microseconds. Each tick advances a four-state machine. That machine raises the track level at the start of every bit and lowers it after one tick for a logic 1, or after two ticks for a logic 0. The low phase has the same length as the high phase. A 1 bit therefore spans two ticks and a 0 bit spans four.

The block does not store packets. An upstream serializer supplies the bits one at a time. On the clock edge where the level rises, the block raises a one-cycle request, and it captures `bit_i` at the end of that request cycle. That bit then sets the shape of the bit that has just started.

An output enable gates only the pin. The state machine keeps running and keeps asking for bits while the track is disabled, so the serializer never stalls.

Top module: `dcc_wave_gen`

## Requirements
- R1: While `rst_ni` is low, and from its release until the first tick, `track_o` and `bit_req_o` are 0. The machine starts at the bit-start state with the level low.
- R2: The machine changes state only on a tick. The first tick comes TICK_CYC clock cycles after reset release, and a tick recurs every TICK_CYC cycles, where TICK_CYC = (CLK_HZ / 1_000_000) * TICK_US.
- R3: On the tick that begins a bit, the level rises. In the first cycle at the new level, `bit_req_o` is 1.
- R4: `bit_i` is captured at the clock edge that ends the cycle in which `bit_req_o` is 1. The captured value sets the shape of the bit that has just started.
- R5: A captured 1 gives TICK_CYC cycles of high level, then TICK_CYC cycles of low level, so the next request follows 2*TICK_CYC cycles later.
- R6: A captured 0 gives 2*TICK_CYC cycles high, then 2*TICK_CYC cycles low, so the next request follows 4*TICK_CYC cycles later.
- R7: `bit_req_o` is a single-cycle pulse, and it is asserted exactly once per transmitted bit.
- R8: When `en_i` is 0, `track_o` is 0 in that same cycle. The state machine, its timing and the bit requests carry on unchanged.
- R9: Changes on `bit_i` outside the capture cycle have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Track output enable |
| bit_i | input | 1 | Next bit from the serializer, valid in the request cycle |
| bit_req_o | output | 1 | One-cycle request for the next bit |
| track_o | output | 1 | Gated track level |

## Verification
The bench answers each request with a bit and then flips `bit_i` in the following cycle. A design that captured late, or that tracked the input continuously, would give the wrong shape to the bit in progress. Each bit's period is measured between requests, and its high time is measured at the pin. This catches a swapped 1/0 shape, a dropped or doubled tick in either phase, and a request that lasts longer than one cycle. Stretches with the enable off check two things: the pin must stay low, and the request spacing must keep its length. A design that froze its state machine while the track was disabled would fail that spacing check. The latency from reset release to the first request is also measured, which exposes an off-by-one in the divider.

// File: rtl/dcc_wave_pkg.sv
package dcc_wave_pkg;
  typedef enum logic [1:0] {
    ST_BIT_START = 2'd0,
    ST_DECIDE    = 2'd1,
    ST_ZERO_FALL = 2'd2,
    ST_ZERO_END  = 2'd3
  } dcc_state_e;
endpackage

// File: rtl/dcc_tick_div.sv
module dcc_tick_div #(
  parameter int TICK_CYC = 5800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/dcc_bit_latch.sv
module dcc_bit_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bit_i,
  output logic cur_bit_o
);
  logic cur_q;

  // capture at the edge that closes the request cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_q <= 1'b0;
    else if (req_i) cur_q <= bit_i;
  end

  assign cur_bit_o = cur_q;

  AST_HOLD_OUTSIDE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(cur_q)); // R9
endmodule

// File: rtl/dcc_phase_fsm.sv
module dcc_phase_fsm
  import dcc_wave_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cur_bit_i,
  output logic level_o,
  output logic req_o
);
  dcc_state_e state_q, state_d;
  logic       level_q, level_d;
  logic       req_q, req_d;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    req_d   = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_BIT_START: begin
          level_d = 1'b1;
          req_d   = 1'b1;
          state_d = ST_DECIDE;
        end
        ST_DECIDE: begin
          if (cur_bit_i) begin
            level_d = 1'b0;
            state_d = ST_BIT_START;
          end else begin
            state_d = ST_ZERO_FALL;
          end
        end
        ST_ZERO_FALL: begin
          level_d = 1'b0;
          state_d = ST_ZERO_END;
        end
        ST_ZERO_END: state_d = ST_BIT_START;
        default:     state_d = ST_BIT_START;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BIT_START;
      level_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
      req_q   <= req_d;
    end
  end

  assign level_o = level_q;
  assign req_o   = req_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R7
  AST_RISE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> req_q); // R3
  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q)); // R2
  AST_ZERO_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO_FALL) |-> level_q); // R6
  AST_ZERO_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO_END) |-> !level_q); // R6
  AST_DECIDE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE) |-> level_q); // R5
endmodule

// File: rtl/dcc_wave_gen.sv
module dcc_wave_gen #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_US = 58
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_req_o,
  output logic track_o
);
  localparam int TICK_CYC_RAW = (CLK_HZ / 1_000_000) * TICK_US;
  // capture must land before the deciding tick
  localparam int TICK_CYC = (TICK_CYC_RAW < 2) ? 2 : TICK_CYC_RAW;

  logic tick;
  logic level;
  logic req;
  logic cur_bit;

  dcc_tick_div #(.TICK_CYC(TICK_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dcc_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cur_bit_i (cur_bit),
    .level_o   (level),
    .req_o     (req)
  );

  dcc_bit_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .bit_i     (bit_i),
    .cur_bit_o (cur_bit)
  );

  assign bit_req_o = req;
  assign track_o   = level & en_i;

  AST_REQ_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_o |-> level); // R3
endmodule

// File: tb/dcc_wave_gen_bench.sv
module dcc_wave_gen_bench;
  localparam int CLK_HZ  = 1_000_000;
  localparam int TICK_US = 4;
  localparam int TC      = 4;

  // {en, bit}
  localparam logic [1:0] VEC [16] = '{
    2'b11, 2'b10, 2'b11, 2'b11, 2'b10, 2'b10, 2'b01, 2'b00,
    2'b01, 2'b11, 2'b00, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic bit_in = 1'b0;
  logic req;
  logic track;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dcc_wave_gen #(.CLK_HZ(CLK_HZ), .TICK_US(TICK_US)) u_dcc_wave_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .bit_i     (bit_in),
    .bit_req_o (req),
    .track_o   (track)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at the negedge where req is high; measures one bit
  task automatic run_bit(input logic e, input logic b, input bit scramble,
                         output int per, output int hi, output int req_w);
    en = e;
    bit_in = b;
    per = 0; hi = 0; req_w = 0;
    #0;
    do begin
      if (track) hi++;
      if (req) req_w++;
      per++;
      @(negedge clk);
      if (per == 1 && scramble) bit_in = ~b;
    end while (!req && per < 100);
  endtask

  initial begin
    int n;
    int per, hi, rw;
    bit stray;
    #1;
    check(track == 1'b0 && req == 1'b0, "R1 outputs in reset", {track, req}, 0);
    repeat (3) @(negedge clk);
    check(track == 1'b0 && req == 1'b0, "R1 outputs held in reset", {track, req}, 0);
    rst_n = 1'b1;
    n = 0;
    stray = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!req && track) stray = 1'b1;
    end while (!req && n < 100);
    check(!stray, "R1 track low before first tick", stray, 0);
    check(n == TC, "R2 first request latency", n, TC);

    // vector walk
    for (int i = 0; i < 16; i++) begin
      logic e, b;
      int exp_per, exp_hi;
      e = VEC[i][1];
      b = VEC[i][0];
      run_bit(e, b, 1'b1, per, hi, rw);
      exp_per = b ? 2 * TC : 4 * TC;
      exp_hi  = e ? (b ? TC : 2 * TC) : 0;
      check(per == exp_per, b ? "R5 one-bit period (R4 R9 R8)" : "R6 zero-bit period (R4 R9 R8)",
            per, exp_per);
      check(hi == exp_hi, e ? (b ? "R5 one-bit high time" : "R6 zero-bit high time")
                            : "R8 track low while disabled", hi, exp_hi);
      check(rw == 1, "R7 single request per bit", rw, 1);
    end

    // R3: level is high in the request cycle itself
    en = 1'b1;
    #0;
    check(track == 1'b1, "R3 level high with request", track, 1);

    // R8: drop enable in the middle of a zero bit's high phase
    bit_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    #0;
    check(track == 1'b0, "R8 immediate gating", track, 0);
    n = 2;
    while (!req && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 4 * TC, "R8 machine runs while disabled", n, 4 * TC);

    // R9: bit held steady then flipped only after capture, two ones back to back
    run_bit(1'b1, 1'b1, 1'b0, per, hi, rw);
    check(per == 2 * TC, "R9 steady one period", per, 2 * TC);
    run_bit(1'b1, 1'b0, 1'b0, per, hi, rw);
    check(hi == 2 * TC, "R6 steady zero high", hi, 2 * TC);

    // R1: asynchronous reset mid-bit
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(track == 1'b0 && req == 1'b0, "R1 async reset clears outputs", {track, req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req && n < 100);
    check(n == TC, "R2 latency after second reset", n, TC);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule